// File: doc/BRIEF.md
# Programmable DMA Request Generator

This block keeps a small control register and, from it, drives the request line that tells a host a DMA transfer may proceed. Software sets the enable, the active level of the line, whether a request is a held level or a counted pulse, and the pulse length in clocks. The register answers at two host offsets, so the same storage appears in two address windows.

A one-cycle data-ready strobe starts a request. In level mode the line stays active until a negation input reports that the end of the data is near. In pulse mode the line stays active for exactly the programmed number of clocks. A width field of zero suppresses requests in both modes. The asynchronous reset input is released into the block through a two-stage synchronizer.

Top module: `dmarq_top`

## Requirements
- R1: After reset the register reads 0x0042: enable 0 (bit 0), polarity 1 (bit 1), mode 0 (bit 2), width 4 (bits 8:4).
- R2: Reads and writes hit the register at offset 0x140E or 0x940E only. `reg_rdata` is combinational on `reg_addr`, and any other offset reads 0 and ignores writes. Bits 15:9 and bit 3 always read 0.
- R3: While enable is 0 the line sits at its inactive level, and data-ready strobes are ignored. Clearing enable during a request makes the line inactive in the cycle after the write edge.
- R4: Polarity 0 means the line is high when active and low when inactive. Polarity 1 inverts both levels.
- R5: In level mode, a data-ready sampled at a clock edge makes the line active from that edge. It stays active until the edge at which `negate` is sampled high. A data-ready that arrives while idle starts a request even if `negate` is high in the same cycle.
- R6: In pulse mode (bit 2 = 1) a data-ready makes the line active for exactly W clocks, where W is the width field (1 to 31).
- R7: With a width field of 0 the line is never activated, in either mode.
- R8: While a request is active, further data-ready strobes are ignored and do not retrigger or extend it. `negate` has no effect in pulse mode or while idle.
- R9: A polarity write during a pulse flips the line's level at the write edge. The pulse still ends after its original W clocks.
- R10: A write in the same cycle as a data-ready does not affect that strobe, which is judged with the register values from before the write. Mode and width writes during an active request do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register offset for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed offset |
| data_ready | input | 1 | One-cycle strobe: data is available |
| negate | input | 1 | End-of-data approach, ends a level request |
| dma_req | output | 1 | DMA request line, polarity per register |

## Verification
The cycle that matters is one in which a register write lands on the same edge as a data-ready strobe or as a running request. Examples are enabling the block on the strobe's cycle, switching mode or width while a level request is held, flipping polarity or clearing enable partway through a pulse, and a strobe together with `negate` while idle. The bench produces each of these on purpose. A behavioural model judges every cycle: it evaluates the strobe against the old register contents and only then applies the write. The line level and the read data are compared after each clock.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
  localparam int REG_W   = 16;
  localparam int PW_W    = 5;
  localparam int EN_BIT  = 0;
  localparam int POL_BIT = 1;
  localparam int MOD_BIT = 2;
  localparam int PW_LSB  = 4;
  localparam int PW_MSB  = PW_LSB + PW_W - 1;
  localparam logic [PW_W-1:0] PW_RST = 5'd4;

  typedef struct packed {
    logic [PW_W-1:0] pw;
    logic            pulse_m;
    logic            pol;
    logic            en;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEVEL = 2'd1,
    ST_PULSE = 2'd2
  } rq_state_e;
endpackage

// File: rtl/dmarq_rst_sync.sv
module dmarq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dmarq_regs.sv
module dmarq_regs
  import dmarq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_WIN  = 2,
  parameter logic [N_WIN*ADDR_W-1:0] WIN_OFS = {16'h940E, 16'h140E}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output ctrl_t             ctrl,
  output logic [REG_W-1:0]  rdata
);
  logic [N_WIN-1:0] win_hit;
  logic             hit;
  logic             wr_en;
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_d;
  logic             unused_wbits;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    assign win_hit[g] = (addr == WIN_OFS[g*ADDR_W +: ADDR_W]);
  end

  assign hit   = |win_hit;
  assign wr_en = wr & hit;
  assign unused_wbits = ^{wdata[REG_W-1:PW_MSB+1], wdata[PW_LSB-1:MOD_BIT+1]};

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.en      = wdata[EN_BIT];
      ctrl_d.pol     = wdata[POL_BIT];
      ctrl_d.pulse_m = wdata[MOD_BIT];
      ctrl_d.pw      = wdata[PW_MSB:PW_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.en      <= 1'b0;
      ctrl_q.pol     <= 1'b1;
      ctrl_q.pulse_m <= 1'b0;
      ctrl_q.pw      <= PW_RST;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[EN_BIT]        = ctrl_q.en;
      rdata[POL_BIT]       = ctrl_q.pol;
      rdata[MOD_BIT]       = ctrl_q.pulse_m;
      rdata[PW_MSB:PW_LSB] = ctrl_q.pw;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/dmarq_seq.sv
module dmarq_seq
  import dmarq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  ctrl_t           ctrl,
  input  logic            data_ready,
  input  logic            negate,
  output rq_state_e       st,
  output logic [PW_W-1:0] cnt,
  output logic            active
);
  rq_state_e       st_q, st_d;
  logic [PW_W-1:0] cnt_q, cnt_d;
  logic            start;

  assign start = data_ready && (ctrl.pw != '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!ctrl.en) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (ctrl.pulse_m) begin
              st_d  = ST_PULSE;
              cnt_d = ctrl.pw;
            end else begin
              st_d  = ST_LEVEL;
            end
          end
        end
        ST_LEVEL: begin
          if (negate) st_d = ST_IDLE;
        end
        ST_PULSE: begin
          if (cnt_q <= 5'd1) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q - 5'd1;
          end
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st     = st_q;
  assign cnt    = cnt_q;
  assign active = (st_q != ST_IDLE) && ctrl.en;
endmodule

// File: rtl/dmarq_drv.sv
module dmarq_drv (
  input  logic active,
  input  logic pol,
  output logic req
);
  always_comb begin
    if (active) req = ~pol;
    else        req = pol;
  end
endmodule

// File: rtl/dmarq_top.sv
module dmarq_top
  import dmarq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              data_ready,
  input  logic              negate,
  output logic              dma_req
);
  logic            rst_sync_n;
  ctrl_t           ctrl_w;
  rq_state_e       st_w;
  logic [PW_W-1:0] cnt_w;
  logic            act_w;

  dmarq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dmarq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .ctrl  (ctrl_w),
    .rdata (reg_rdata)
  );

  dmarq_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctrl       (ctrl_w),
    .data_ready (data_ready),
    .negate     (negate),
    .st         (st_w),
    .cnt        (cnt_w),
    .active     (act_w)
  );

  dmarq_drv u_drv (
    .active (act_w),
    .pol    (ctrl_w.pol),
    .req    (dma_req)
  );
endmodule

// File: rtl/dmarq_chk.sv
module dmarq_chk
  import dmarq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dma_req,
  input logic [REG_W-1:0] reg_rdata,
  input ctrl_t            ctrl,
  input rq_state_e        st,
  input logic [PW_W-1:0]  cnt,
  input logic             active,
  input logic             data_ready,
  input logic             negate
);
  logic [PW_W:0]   run_q;
  logic [PW_W-1:0] cap_q;
  logic            prev_pulse_q;
  logic            prev_en_q;
  logic            pulse_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= '0;
      cap_q        <= '0;
      prev_pulse_q <= 1'b0;
      prev_en_q    <= 1'b0;
    end else begin
      run_q        <= (st == ST_PULSE) ? run_q + 1'b1 : '0;
      prev_pulse_q <= (st == ST_PULSE);
      prev_en_q    <= ctrl.en;
      if (st == ST_IDLE && ctrl.en && ctrl.pulse_m && data_ready && ctrl.pw != '0)
        cap_q <= ctrl.pw;
    end
  end

  assign pulse_end = prev_pulse_q && (st != ST_PULSE) && prev_en_q;

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[REG_W-1:PW_MSB+1] == '0) && (reg_rdata[PW_LSB-1] == 1'b0));

  // R3
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> (dma_req == ctrl.pol));

  // R5
  level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LEVEL && ctrl.en && negate) |=> !active);

  // R7
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && ctrl.pw == '0) |=> !active);

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end |-> (run_q == {1'b0, cap_q}));

  // R9
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PULSE && $past(st) == ST_PULSE) |-> (cnt == PW_W'($past(cnt) - 5'd1)));
endmodule

bind dmarq_top dmarq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .dma_req    (dma_req),
  .reg_rdata  (reg_rdata),
  .ctrl       (ctrl_w),
  .st         (st_w),
  .cnt        (cnt_w),
  .active     (act_w),
  .data_ready (data_ready),
  .negate     (negate)
);

// File: tb/sim_dmarq_top.sv
`timescale 1ns/1ps
module sim_dmarq_top;
  localparam logic [15:0] OFS_S = 16'h140E;
  localparam logic [15:0] OFS_L = 16'h940E;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        data_ready;
  logic        negate;
  logic        dma_req;

  int    n_cmp;
  int    n_bad;
  string cur_req;

  dmarq_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .data_ready (data_ready),
    .negate     (negate),
    .dma_req    (dma_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference
  bit m_en, m_pol, m_pulse;
  int m_pw;
  int m_mode;   // 0 idle, 1 level, 2 pulse
  int m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pol = 1; m_pulse = 0; m_pw = 4; m_mode = 0; m_left = 0;
    end else begin
      if (!m_en) m_mode = 0;
      else if (m_mode == 0) begin
        if (data_ready && m_pw != 0) begin
          m_mode = m_pulse ? 2 : 1;
          m_left = m_pw;
        end
      end else if (m_mode == 1) begin
        if (negate) m_mode = 0;
      end else begin
        m_left = m_left - 1;
        if (m_left == 0) m_mode = 0;
      end
      if (reg_wr && (reg_addr == OFS_S || reg_addr == OFS_L)) begin
        m_en    = reg_wdata[0];
        m_pol   = reg_wdata[1];
        m_pulse = reg_wdata[2];
        m_pw    = (int'(reg_wdata) >> 4) & 31;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit          exp_req;
      logic [15:0] exp_rd;
      exp_req = (m_mode != 0 && m_en) ? !m_pol : m_pol;
      exp_rd  = '0;
      if (reg_addr == OFS_S || reg_addr == OFS_L)
        exp_rd = 16'(m_en) | (16'(m_pol) << 1) | (16'(m_pulse) << 2) | (16'(m_pw) << 4);
      n_cmp++;
      if (dma_req !== exp_req) begin
        n_bad++;
        $display("FAIL %s: dma_req actual=%0b expected=%0b at %0t", cur_req, dma_req, exp_req, $time);
      end
      n_cmp++;
      if (reg_rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL %s: reg_rdata actual=%h expected=%h at %0t", cur_req, reg_rdata, exp_rd, $time);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 0; data_ready = 0; negate = 0;
    end
  endtask

  task automatic wreg(logic [15:0] a, logic [15:0] d, bit dr = 0);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; data_ready = dr; negate = 0;
    @(negedge clk);
    reg_wr = 0; data_ready = 0;
  endtask

  task automatic strobe(bit neg = 0);
    @(negedge clk);
    reg_wr = 0; data_ready = 1; negate = neg;
    @(negedge clk);
    data_ready = 0; negate = 0;
  endtask

  task automatic neg_pulse();
    @(negedge clk);
    reg_wr = 0; data_ready = 0; negate = 1;
    @(negedge clk);
    negate = 0;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cur_req = "R1";
    rst_n = 0; reg_wr = 0; reg_addr = OFS_S; reg_wdata = '0;
    data_ready = 0; negate = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);

    // R1 reset value at both offsets, R2 unmapped offset reads zero
    reg_addr = OFS_L; idle(2);
    cur_req = "R2"; reg_addr = 16'h1410; idle(2);

    // R2 reserved bits, mirrored window, ignored stray write
    wreg(OFS_S, 16'hFFFF);
    reg_addr = OFS_L; idle(1);
    wreg(16'h140C, 16'h0000);
    reg_addr = OFS_S; idle(1);
    wreg(OFS_S, 16'h0042);

    // R3 disabled: strobes ignored
    cur_req = "R3";
    wreg(OFS_S, 16'h0034);
    strobe(); idle(6);

    // R5 level mode, polarity 0
    cur_req = "R5";
    wreg(OFS_L, 16'h0041);
    neg_pulse(); idle(2);
    strobe(); idle(5); neg_pulse(); idle(3);
    strobe(1); idle(3); neg_pulse(); idle(2);

    // R8 strobe during level request does not restart it
    cur_req = "R8";
    strobe(); idle(2); strobe(); idle(2); neg_pulse(); idle(3);

    // R6 pulse widths 3, 1, 31
    cur_req = "R6";
    wreg(OFS_S, 16'h0035); strobe(); idle(6);
    wreg(OFS_S, 16'h0015); strobe(); idle(3);
    wreg(OFS_S, 16'h01F5); strobe(); idle(34);

    // R8 strobe and negate during a pulse ignored
    cur_req = "R8";
    wreg(OFS_S, 16'h0065); strobe(); idle(2); strobe(); neg_pulse(); idle(6);

    // R7 zero width in both modes
    cur_req = "R7";
    wreg(OFS_S, 16'h0005); strobe(); idle(4);
    wreg(OFS_S, 16'h0001); strobe(); idle(4); neg_pulse();

    // R4 active-low line
    cur_req = "R4";
    wreg(OFS_S, 16'h0037); strobe(); idle(5);
    wreg(OFS_S, 16'h0043); strobe(); idle(3); neg_pulse(); idle(2);

    // R9 polarity flip mid-pulse
    cur_req = "R9";
    wreg(OFS_S, 16'h0085); strobe(); idle(2);
    wreg(OFS_S, 16'h0087); idle(3);
    wreg(OFS_S, 16'h0085); idle(6);

    // R10 enable written on the strobe's cycle: strobe judged with enable 0
    cur_req = "R10";
    wreg(OFS_S, 16'h0034); idle(1);
    wreg(OFS_S, 16'h0035, 1); idle(5);
    // disable written on strobe cycle: strobe judged with enable 1
    wreg(OFS_S, 16'h0034, 1); idle(4);
    // mode and width change during a level request
    wreg(OFS_S, 16'h0041); strobe(); idle(2);
    wreg(OFS_S, 16'h0025); idle(6); neg_pulse(); idle(3);

    // R3 clearing enable mid-pulse ends it
    cur_req = "R3";
    wreg(OFS_S, 16'h00A5); strobe(); idle(2);
    wreg(OFS_S, 16'h00A4); idle(4);
    wreg(OFS_S, 16'h00A5); strobe(); idle(12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule